// File: doc/BRIEF.md
# Serial Asynchronous Receiver with Break Handling

This block receives characters from an asynchronous serial line. It finds a start bit and shifts in 8 or 9 data bits, least significant bit first. It then takes an optional parity bit and checks one or two stop bits. The line is sampled on an external tick that runs at sixteen times the bit rate. The level of each bit is the majority of the three samples taken at the middle of the bit. A finished word moves into a receive data register. A six-bit status word reports data-ready, idle and four error flags. An interrupt output is asserted when interrupts are enabled.

A line held low for longer than a frame is a break. The receiver delivers it as an all-zero character with the framing error set, once the programmed frame length has passed. It then waits for the line to go high before it looks for another start bit. Software clears data-ready and the error flags in two steps: it reads the status word, then reads the data register.

Top module: `serial_rx_core`

## Requirements
- R1: A frame that completes while data-ready is clear loads its data bits into `data_o`, least significant bit first. The bit count is 9 when `cfg_nine`=1 and 8 otherwise, and unused upper bits read 0. Data-ready (`stat_o[0]`) is set. Status bits: [0] ready, [1] idle, [2] framing, [3] noise, [4] parity, [5] overrun.
- R2: `irq_o` is 1 only while `cfg_irq_en` is 1 and data-ready or overrun is set, and it lags those flags by one cycle. With `cfg_irq_en`=0 it stays 0.
- R3: Data-ready and all error flags clear on a `rd_data` pulse only if a `rd_stat` pulse came before it. A `rd_data` pulse without an earlier status read has no effect. A frame that completes between the two pulses cancels the pending status read.
- R4: A stop bit sampled low sets the framing flag.
- R5: When `cfg_par_en`=1, one parity bit follows the data bits. The total count of ones must be even (`cfg_par_odd`=0) or odd (`cfg_par_odd`=1). A mismatch sets the parity flag.
- R6: If the three mid-bit samples of any bit in the frame disagree, the noise flag is set. The bit still takes the majority value.
- R7: A frame that completes while data-ready is still set sets the overrun flag. The new word is dropped and `data_o` keeps its old value.
- R8: A line held low completes after the programmed frame length. It gives data 0, the framing flag and data-ready. No new start bit is accepted until the line has been high.
- R9: The idle flag (`stat_o[1]`) is 0 from the detection of a start bit until the last stop bit has been sampled. It is 1 otherwise, including while a break keeps the line low after its frame has completed.
- R10: A start bit whose mid-bit majority is high is discarded. No flag or data changes.
- R11: Reset clears the data register, all flags and `irq_o`, and sets idle.
- R12: With `cfg_two_stop`=1, two stop bits are sampled, and a low second stop bit sets the framing flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| cfg_nine | input | 1 | 1: 9 data bits, 0: 8 data bits |
| cfg_two_stop | input | 1 | 1: two stop bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_irq_en | input | 1 | Interrupt enable |
| rd_stat | input | 1 | Status read strobe |
| rd_data | input | 1 | Data read strobe |
| stat_o | output | 6 | Status flags |
| data_o | output | 9 | Receive data register |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the read strobes are single-cycle pulses and that `tick16` is never high on two consecutive cycles. They also assume the configuration inputs stay constant while a frame is on the line. The bench changes configuration only between frames, with the line idle. It starts each frame at a fixed phase of its own tick divider and leaves gaps between strobes. A noise glitch is exactly one tick period wide, so it catches exactly one of the three mid-bit samples.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int STAT_W = 6;
  localparam int ST_RDY = 0;
  localparam int ST_IDLE = 1;
  localparam int ST_FE = 2;
  localparam int ST_NE = 3;
  localparam int ST_PE = 4;
  localparam int ST_OVR = 5;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_BITS,
    S_STOP,
    S_HOLD
  } rx_state_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd,
  input  logic              cfg_nine,
  input  logic              cfg_two_stop,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o,
  output logic              fe_o,
  output logic              ne_o,
  output logic              pe_o,
  output logic              idle_o
);
  localparam int PW = $clog2(OSR);
  localparam int IW = $clog2(DATA_W + 2);
  localparam logic [PW-1:0] PH_A   = PW'(OSR/2 - 1);
  localparam logic [PW-1:0] PH_B   = PW'(OSR/2);
  localparam logic [PW-1:0] PH_C   = PW'(OSR/2 + 1);
  localparam logic [PW-1:0] PH_END = PW'(OSR - 1);

  rx_state_t         st;
  logic [PW-1:0]     ph;
  logic [IW-1:0]     idx, ndata, nbits;
  logic              stop_n;
  logic [1:0]        votes, tot;
  logic [DATA_W-1:0] shreg;
  logic              par_q, ferr_acc, nacc;
  logic              bitv, noisy, last_stop, par_bad;

  always_comb begin
    ndata     = cfg_nine ? IW'(DATA_W) : IW'(DATA_W - 1);
    nbits     = ndata + IW'(cfg_par_en);
    tot       = votes + {1'b0, rxd};
    bitv      = tot[1];
    noisy     = (tot != 2'd0) && (tot != 2'd3);
    last_stop = (stop_n == cfg_two_stop);
    par_bad   = cfg_par_en && ((^shreg ^ par_q) != cfg_par_odd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      ph       <= '0;
      idx      <= '0;
      stop_n   <= 1'b0;
      votes    <= '0;
      shreg    <= '0;
      par_q    <= 1'b0;
      ferr_acc <= 1'b0;
      nacc     <= 1'b0;
      done_o   <= 1'b0;
      word_o   <= '0;
      fe_o     <= 1'b0;
      ne_o     <= 1'b0;
      pe_o     <= 1'b0;
      idle_o   <= 1'b1;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: begin
          if (tick && !rxd) begin
            st       <= S_START;
            ph       <= PW'(1);
            idle_o   <= 1'b0;
            idx      <= '0;
            stop_n   <= 1'b0;
            shreg    <= '0;
            par_q    <= 1'b0;
            ferr_acc <= 1'b0;
            nacc     <= 1'b0;
          end
        end
        S_HOLD: begin
          if (rxd) st <= S_IDLE;
        end
        default: begin
          if (tick) begin
            ph <= (ph == PH_END) ? '0 : ph + PW'(1);
            if (ph == PH_A) votes <= {1'b0, rxd};
            if (ph == PH_B) votes <= tot;
            if (ph == PH_C) begin
              nacc <= nacc | noisy;
              case (st)
                S_START: begin
                  if (bitv) begin
                    st     <= S_IDLE;
                    idle_o <= 1'b1;
                  end
                end
                S_BITS: begin
                  if (idx < ndata) shreg[idx] <= bitv;
                  else             par_q      <= bitv;
                end
                S_STOP: begin
                  if (!bitv) ferr_acc <= 1'b1;
                  if (last_stop) begin
                    done_o <= 1'b1;
                    word_o <= shreg;
                    fe_o   <= ferr_acc | !bitv;
                    ne_o   <= nacc | noisy;
                    pe_o   <= par_bad;
                    idle_o <= 1'b1;
                    st     <= bitv ? S_IDLE : S_HOLD;
                  end
                end
                default: ;
              endcase
            end
            if (ph == PH_END) begin
              case (st)
                S_START: begin
                  st  <= S_BITS;
                  idx <= '0;
                end
                S_BITS: begin
                  if (idx == nbits - IW'(1)) begin
                    st     <= S_STOP;
                    stop_n <= 1'b0;
                  end else begin
                    idx <= idx + IW'(1);
                  end
                end
                S_STOP:  stop_n <= 1'b1;
                default: ;
              endcase
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_regs.sv
module serial_rx_regs
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              fe_i,
  input  logic              ne_i,
  input  logic              pe_i,
  input  logic              idle_i,
  input  logic              rd_stat,
  input  logic              rd_data,
  input  logic              irq_en,
  output logic [DATA_W-1:0] data_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  logic rdy, fe, ne, pe, ovr, armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      rdy    <= 1'b0;
      fe     <= 1'b0;
      ne     <= 1'b0;
      pe     <= 1'b0;
      ovr    <= 1'b0;
      armed  <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= irq_en & (rdy | ovr);
      if (done_i) begin
        armed <= 1'b0;
        if (rdy) begin
          ovr <= 1'b1;
        end else begin
          data_o <= word_i;
          rdy    <= 1'b1;
          fe     <= fe_i;
          ne     <= ne_i;
          pe     <= pe_i;
        end
      end else begin
        if (rd_stat) armed <= 1'b1;
        if (rd_data && armed) begin
          rdy   <= 1'b0;
          fe    <= 1'b0;
          ne    <= 1'b0;
          pe    <= 1'b0;
          ovr   <= 1'b0;
          armed <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    stat_o          = '0;
    stat_o[ST_RDY]  = rdy;
    stat_o[ST_IDLE] = idle_i;
    stat_o[ST_FE]   = fe;
    stat_o[ST_NE]   = ne;
    stat_o[ST_PE]   = pe;
    stat_o[ST_OVR]  = ovr;
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int DATA_W      = 9,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rx_in,
  input  logic              cfg_nine,
  input  logic              cfg_two_stop,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_irq_en,
  input  logic              rd_stat,
  input  logic              rd_data,
  output logic [STAT_W-1:0] stat_o,
  output logic [DATA_W-1:0] data_o,
  output logic              irq_o
);
  logic              rxs;
  logic              frm_done, frm_fe, frm_ne, frm_pe, frm_idle;
  logic [DATA_W-1:0] frm_word;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d_i(rx_in), .q_o(rxs)
  );

  serial_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) frame_i (
    .clk(clk), .rst(rst), .tick(tick16), .rxd(rxs),
    .cfg_nine(cfg_nine), .cfg_two_stop(cfg_two_stop),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .done_o(frm_done), .word_o(frm_word), .fe_o(frm_fe),
    .ne_o(frm_ne), .pe_o(frm_pe), .idle_o(frm_idle)
  );

  serial_rx_regs #(.DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst), .done_i(frm_done), .word_i(frm_word),
    .fe_i(frm_fe), .ne_i(frm_ne), .pe_i(frm_pe), .idle_i(frm_idle),
    .rd_stat(rd_stat), .rd_data(rd_data), .irq_en(cfg_irq_en),
    .data_o(data_o), .stat_o(stat_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk #(
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              rdy,
  input logic              idle,
  input logic              rxs,
  input logic              rd_data,
  input logic              irq_en,
  input logic              irq_o,
  input logic [DATA_W-1:0] data_o
);
  // R1
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy) |-> $past(done));

  // R3
  ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy) |-> $past(rd_data));

  // R7
  overrun_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (done && rdy) |=> $stable(data_o));

  // R2
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(irq_en));

  // R9
  idle_start_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(idle) |-> !$past(rxs));
endmodule

bind serial_rx_core serial_rx_core_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .done(frm_done), .rdy(stat_o[0]), .idle(stat_o[1]),
  .rxs(rxs), .rd_data(rd_data), .irq_en(cfg_irq_en), .irq_o(irq_o),
  .data_o(data_o)
);

// File: tb/serial_rx_core_tb_top.sv
module serial_rx_core_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cnt = 2'd0;
  logic tick16;
  logic rx = 1'b1;
  logic nine = 1'b0, two = 1'b0, pen = 1'b0, podd = 1'b0, irq_en = 1'b0;
  logic rd_stat = 1'b0, rd_data = 1'b0;
  logic [5:0] stat;
  logic [8:0] data;
  logic irq;
  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always_ff @(posedge clk) cnt <= cnt + 2'd1;
  assign tick16 = (cnt == 2'd0);

  serial_rx_core dut_i (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_in(rx),
    .cfg_nine(nine), .cfg_two_stop(two), .cfg_par_en(pen),
    .cfg_par_odd(podd), .cfg_irq_en(irq_en), .rd_stat(rd_stat),
    .rd_data(rd_data), .stat_o(stat), .data_o(data), .irq_o(irq)
  );

  // Fields: [15] nine, [14] two stops, [13] parity on, [12] odd,
  // [11] corrupt parity, [10] last stop low, [8:0] data
  localparam int NV = 9;
  localparam logic [15:0] VEC [0:NV-1] = '{
    16'h00A5, 16'h81C3, 16'h603C, 16'h3081, 16'h2855,
    16'h04FF, 16'hC4F0, 16'hB901, 16'h01FF
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_time(input logic v);
    rx = v;
    wait_clk(64);
  endtask

  task automatic send(input logic [8:0] d, input logic pbit, input logic badstop,
                      input int glitch);
    @(negedge clk);
    while (cnt != 2'd1) @(negedge clk);
    bit_time(1'b0);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      if (i == glitch) begin
        rx = d[i];  wait_clk(34);
        rx = ~d[i]; wait_clk(4);
        rx = d[i];  wait_clk(26);
      end else begin
        bit_time(d[i]);
      end
    end
    if (pen) bit_time(pbit);
    if (two) bit_time(1'b1);
    bit_time(!badstop);
    rx = 1'b1;
    wait_clk(8);
  endtask

  task automatic read_clear();
    @(negedge clk) rd_stat = 1'b1;
    @(negedge clk) begin rd_stat = 1'b0; rd_data = 1'b1; end
    @(negedge clk) rd_data = 1'b0;
    wait_clk(2);
  endtask

  initial begin
    wait_clk(3);
    // R11 reset state
    chk("R11 status after reset", {10'd0, stat}, 16'h0002);
    chk("R11 data after reset", {7'd0, data}, 16'h0000);
    chk("R11 irq after reset", {15'd0, irq}, 16'h0000);
    rst = 1'b0;
    wait_clk(4);

    // Vector table: R1 R4 R5 R12
    for (int v = 0; v < NV; v++) begin
      logic [15:0] e;
      logic [8:0] ed;
      logic pb, fe, pe;
      e = VEC[v];
      nine = e[15]; two = e[14]; pen = e[13]; podd = e[12];
      ed = nine ? e[8:0] : {1'b0, e[7:0]};
      pb = (^ed) ^ podd ^ e[11];
      fe = e[10];
      pe = pen & e[11];
      wait_clk(2);
      send(e[8:0], pb, e[10], -1);
      chk($sformatf("R1 R4 R5 R12 vector %0d status", v), {10'd0, stat},
          {10'd0, 1'b0, pe, 1'b0, fe, 2'b11});
      chk($sformatf("R1 vector %0d data", v), {7'd0, data}, {7'd0, ed});
      if (v == 0) chk("R2 irq low while disabled", {15'd0, irq}, 16'h0000);
      read_clear();
      chk($sformatf("R3 vector %0d cleared", v), {10'd0, stat}, 16'h0002);
    end

    // R3 data read alone, R7 overrun, R2 irq
    nine = 1'b0; two = 1'b0; pen = 1'b0; podd = 1'b0; irq_en = 1'b1;
    wait_clk(2);
    send(9'h012, 1'b0, 1'b0, -1);
    chk("R2 irq with ready", {15'd0, irq}, 16'h0001);
    @(negedge clk) rd_data = 1'b1;
    @(negedge clk) rd_data = 1'b0;
    wait_clk(2);
    chk("R3 data read without status read", {10'd0, stat}, 16'h0003);
    @(negedge clk) rd_stat = 1'b1;
    @(negedge clk) rd_stat = 1'b0;
    send(9'h0C7, 1'b0, 1'b0, -1);
    chk("R7 overrun status", {10'd0, stat}, 16'h0023);
    chk("R7 old data kept", {7'd0, data}, 16'h0012);
    @(negedge clk) rd_data = 1'b1;
    @(negedge clk) rd_data = 1'b0;
    wait_clk(2);
    chk("R3 arming cancelled by new frame", {10'd0, stat}, 16'h0023);
    read_clear();
    chk("R3 overrun cleared", {10'd0, stat}, 16'h0002);
    chk("R2 irq drops", {15'd0, irq}, 16'h0000);
    irq_en = 1'b0;

    // R6 noise
    send(9'h033, 1'b0, 1'b0, 2);
    chk("R6 noise status", {10'd0, stat}, 16'h000B);
    chk("R6 majority data", {7'd0, data}, 16'h0033);
    read_clear();

    // R10 false start
    @(negedge clk);
    while (cnt != 2'd1) @(negedge clk);
    rx = 1'b0; wait_clk(16);
    rx = 1'b1; wait_clk(128);
    chk("R10 false start ignored", {10'd0, stat}, 16'h0002);

    // R8 R9 break
    @(negedge clk);
    while (cnt != 2'd1) @(negedge clk);
    rx = 1'b0;
    wait_clk(128);
    chk("R9 idle low during frame", {15'd0, stat[1]}, 16'h0000);
    wait_clk(576);
    chk("R8 R9 break status", {10'd0, stat}, 16'h0007);
    chk("R8 break data zero", {7'd0, data}, 16'h0000);
    wait_clk(600);
    read_clear();
    wait_clk(300);
    chk("R8 no frame while low", {10'd0, stat}, 16'h0002);
    rx = 1'b1;
    wait_clk(128);
    chk("R8 no frame on release", {10'd0, stat}, 16'h0002);
    send(9'h05A, 1'b0, 1'b0, -1);
    chk("R8 recovered after break", {7'd0, data}, 16'h005A);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule